// File: doc/BRIEF.md
# Multiplexed Processor Bus Cycle Sequencer

This block produces the external bus timing for an 8-bit processor core whose 16-bit address reaches a 64 KB space. The low address byte and the data byte share one set of byte-wide pins. The core asks for a single machine cycle: an opcode fetch, a memory read, a memory write, an I/O read or an I/O write. The sequencer then steps through T-states. It drives the high address byte, the shared byte lines with their output enable, a one-T-state address-latch strobe, a memory/I/O select, and active-low read and write strobes.

Slow devices stretch a cycle by holding the ready input low. Each low sample adds one wait T-state. An external master can ask for the bus with a hold request. The sequencer finishes any cycle in flight, then floats every bus output and raises a hold acknowledge until the request drops.

On the core side, `req_ack` pulses in the cycle a request is taken. `done` pulses in the cycle after the last T-state. For reads, `rdata` carries the captured byte in that cycle.

Top module: `bus_cycle_seq`

## Requirements
- R1: The request kind is encoded as 0 = opcode fetch, 1 = memory read, 2 = memory write, 3 = I/O read, 4 = I/O write, on `req_kind`. An opcode fetch lasts four T-states (T1 to T4), and every other kind lasts three (T1 to T3), when no wait states are added. `done` is high for one clock, in the cycle after the last T-state.
- R2: `ale` is high exactly during T1. During T1 the shared lines carry `req_addr[7:0]` with `ad_oe` high. `ale` is low in every other state.
- R3: `io_sel` is 1 during the T-states of kinds 3 and 4. It is 0 during the T-states of kinds 0, 1 and 2.
- R4: `rd_n` is low only in T2, wait states and T3 of kinds 0, 1 and 3. `wr_n` is low only in those same states of kinds 2 and 4. The two are never low together.
- R5: In the data phase (T2, waits, T3), a write drives `req_wdata` on `ad_out` with `ad_oe` high, and a read keeps `ad_oe` low. The byte on `ad_in` at the end of T3 appears on `rdata` in the `done` cycle.
- R6: `ready` is sampled at the end of T2 and at the end of each wait state. Each low sample inserts one wait T-state, during which the strobes and the shared-line outputs stay unchanged.
- R7: A `hold` raised during a cycle does not cut that cycle short. After it completes, `hlda` goes high with `bus_oe`, `ad_oe` low and both strobes high, and stays so until `hold` drops.
- R8: In idle, an active `hold` takes priority over a pending request: `req_ack` stays low while `hold` is high.
- R9: After reset, `ale`, `hlda`, `done`, `req_ack` are 0, `rd_n` and `wr_n` are 1, and `bus_oe` is 1.
- R10: `addr_hi` equals `req_addr[15:8]` throughout T1 to T4 and any wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core requests a machine cycle |
| req_kind | input | 3 | Cycle kind (see R1) |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data |
| req_ack | output | 1 | Request taken this cycle |
| done | output | 1 | Cycle completed; read data valid |
| rdata | output | 8 | Captured read data |
| ready | input | 1 | Device ready; low inserts waits |
| hold | input | 1 | External master requests the bus |
| hlda | output | 1 | Bus released to external master |
| bus_oe | output | 1 | Enable for address and control outputs |
| addr_hi | output | 8 | High address byte |
| ad_out | output | 8 | Shared address/data byte, outgoing |
| ad_oe | output | 1 | Output enable for the shared byte |
| ad_in | input | 8 | Shared address/data byte, incoming |
| ale | output | 1 | Address latch strobe |
| io_sel | output | 1 | 0 = memory, 1 = I/O |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
A hold request and a wait-stretched cycle can be in effect together. The bench raises `hold` during T2 of a read that also gets two wait states. It checks that the strobes, wait states and data capture run to the end unchanged, that `done` comes first with `hlda` still low, and that `hlda` rises only in the next cycle. A second collision, `hold` and `req_valid` both high in idle, is judged by `req_ack` staying low until `hold` drops.

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ack,
  output logic          done,
  output logic [DW-1:0] rdata,
  input  logic          ready,
  input  logic          hold,
  output logic          hlda,
  output logic          bus_oe,
  output logic [AW-DW-1:0] addr_hi,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic          ale,
  output logic          io_sel,
  output logic          rd_n,
  output logic          wr_n
);
  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_TW, S_T3, S_T4, S_HOLD} st_t;

  st_t           st;
  logic [2:0]    kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  logic is_fetch, is_write, is_io, in_cyc, data_ph, last_t;

  assign is_fetch = (kind_q == 3'd0);
  assign is_write = (kind_q == 3'd2) || (kind_q == 3'd4);
  assign is_io    = (kind_q == 3'd3) || (kind_q == 3'd4);
  assign in_cyc   = (st == S_T1) || (st == S_T2) || (st == S_TW) || (st == S_T3) || (st == S_T4);
  assign data_ph  = (st == S_T2) || (st == S_TW) || (st == S_T3);
  assign last_t   = ((st == S_T3) && !is_fetch) || (st == S_T4);

  assign req_ack = (st == S_IDLE) && req_valid && !hold;
  assign hlda    = (st == S_HOLD);
  assign bus_oe  = (st != S_HOLD);
  assign ale     = (st == S_T1);
  assign io_sel  = in_cyc && is_io;
  assign rd_n    = !(data_ph && !is_write);
  assign wr_n    = !(data_ph && is_write);
  assign addr_hi = addr_q[AW-1:DW];
  assign ad_oe   = (st == S_T1) || (data_ph && is_write);
  assign ad_out  = (st == S_T1) ? addr_q[DW-1:0] : wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      kind_q  <= 3'd0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
      done    <= 1'b0;
    end else begin
      done <= last_t;
      if (st == S_T3 && !is_write) rdata <= ad_in;
      unique case (st)
        S_IDLE: begin
          if (hold) st <= S_HOLD;
          else if (req_valid) begin
            st      <= S_T1;
            kind_q  <= req_kind;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
          end
        end
        S_T1:   st <= S_T2;
        S_T2:   st <= ready ? S_T3 : S_TW;
        S_TW:   st <= ready ? S_T3 : S_TW;
        S_T3:   st <= is_fetch ? S_T4 : S_IDLE;
        S_T4:   st <= S_IDLE;
        S_HOLD: st <= hold ? S_HOLD : S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R2
  ale_drives_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> ad_oe && rd_n && wr_n);

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> !bus_oe && !ad_oe && rd_n && wr_n && !ale);

  // R6
  wait_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TW) |-> $stable(rd_n) && $stable(wr_n) && $stable(ad_oe) && $stable(ad_out));

  // R1
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T3 || st == S_T4) && $past(st) != S_IDLE && last_t |=> done);

  // R8
  hold_blocks_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !req_ack);
endmodule

// File: tb/bus_cycle_seq_tb.sv
module bus_cycle_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_kind = 3'd0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0] req_wdata = 8'h0;
  logic req_ack, done, hlda, bus_oe, ad_oe, ale, io_sel, rd_n, wr_n;
  logic [7:0] rdata, addr_hi, ad_out;
  logic ready = 1'b1;
  logic hold = 1'b0;
  logic [7:0] ad_in = 8'h00;

  int vecs = 0;
  int errs = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bus_cycle_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack), .done(done),
    .rdata(rdata), .ready(ready), .hold(hold), .hlda(hlda), .bus_oe(bus_oe),
    .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale),
    .io_sel(io_sel), .rd_n(rd_n), .wr_n(wr_n)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {kind, addr, wdata, waits, din}
  localparam logic [38:0] VEC [6] = '{
    {3'd0, 16'h2050, 8'h00, 4'd0, 8'h3E},
    {3'd1, 16'h81A7, 8'h00, 4'd1, 8'hC4},
    {3'd2, 16'h4F0C, 8'h5A, 4'd0, 8'h00},
    {3'd3, 16'h0033, 8'h00, 4'd2, 8'h9B},
    {3'd4, 16'h00F1, 8'hA5, 4'd1, 8'h00},
    {3'd0, 16'hFFFF, 8'h00, 4'd3, 8'h71}
  };

  task automatic run_cycle(input logic [2:0] k, input logic [15:0] a, input logic [7:0] wd,
                           input int waits, input logic [7:0] din, input bit hold_mid);
    logic wr, io, rdk;
    wr  = (k == 3'd2) || (k == 3'd4);
    io  = (k == 3'd3) || (k == 3'd4);
    rdk = !wr;
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
    #1;
    chk("R8 ack in idle", 16'(req_ack), 16'd1);
    @(negedge clk);
    req_valid = 1'b0;
    ready = (waits == 0);
    chk("R2 ale in T1", 16'(ale), 16'd1);
    chk("R2 low addr in T1", {7'd0, ad_oe, ad_out}, {7'd0, 1'b1, a[7:0]});
    chk("R10 high addr T1", 16'(addr_hi), 16'(a[15:8]));
    chk("R3 io_sel", 16'(io_sel), 16'(io));
    chk("R4 no strobe in T1", {14'd0, rd_n, wr_n}, 16'd3);
    @(negedge clk);
    if (hold_mid) hold = 1'b1;
    chk("R2 ale low T2", 16'(ale), 16'd0);
    chk("R4 strobes T2", {14'd0, rd_n, wr_n}, {14'd0, !rdk, !wr});
    chk("R5 data phase T2", {7'd0, ad_oe, wr ? ad_out : 8'h00}, {7'd0, wr, wr ? wd : 8'h00});
    for (int w = 0; w < waits; w++) begin
      @(negedge clk);
      ready = (w == waits - 1);
      chk("R6 wait strobes", {14'd0, rd_n, wr_n, 8'd0} >> 8, {14'd0, !rdk, !wr});
      chk("R6 wait ad_oe", 16'(ad_oe), 16'(wr));
      chk("R10 high addr wait", 16'(addr_hi), 16'(a[15:8]));
      chk("R7 no hlda mid cycle", 16'(hlda), 16'd0);
    end
    @(negedge clk);
    ready = 1'b1;
    ad_in = din;
    chk("R4 strobes T3", {14'd0, rd_n, wr_n}, {14'd0, !rdk, !wr});
    chk("R1 no early done", 16'(done), 16'd0);
    chk("R3 io_sel T3", 16'(io_sel), 16'(io));
    if (k == 3'd0) begin
      @(negedge clk);
      ad_in = 8'h00;
      chk("R1 fetch T4 strobes off", {14'd0, rd_n, wr_n}, 16'd3);
      chk("R1 fetch T4 no done", 16'(done), 16'd0);
      chk("R10 high addr T4", 16'(addr_hi), 16'(a[15:8]));
    end
    @(negedge clk);
    ad_in = 8'h00;
    chk("R1 done after last T", 16'(done), 16'd1);
    chk("R7 hlda after cycle only", 16'(hlda), 16'd0);
    if (rdk) chk("R5 read data", 16'(rdata), 16'(din));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset strobes", {13'd0, rd_n, wr_n, ale}, 16'd6);
    chk("R9 reset hlda/done/ack", {13'd0, hlda, done, req_ack}, 16'd0);
    chk("R9 reset bus_oe", 16'(bus_oe), 16'd1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      run_cycle(VEC[i][38:36], VEC[i][35:20], VEC[i][19:12], int'(VEC[i][11:8]), VEC[i][7:0], 1'b0);
      @(negedge clk);
      chk("R1 done single pulse", 16'(done), 16'd0);
    end
    // R8: hold in idle beats pending request
    hold = 1'b1; req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'h1234;
    #1;
    chk("R8 no ack under hold", 16'(req_ack), 16'd0);
    @(negedge clk);
    chk("R7 hlda in hold", 16'(hlda), 16'd1);
    chk("R7 buses released", {14'd0, bus_oe, ad_oe}, 16'd0);
    chk("R8 still no ack", 16'(req_ack), 16'd0);
    @(negedge clk);
    chk("R7 hold persists", 16'(hlda), 16'd1);
    hold = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    chk("R7 hlda drops", {14'd0, hlda, bus_oe}, 16'd1);
    // R7 with waits: hold raised in T2 of a stretched read
    run_cycle(3'd1, 16'hBEEF, 8'h00, 2, 8'h6D, 1'b1);
    @(negedge clk);
    chk("R7 hlda after completion", 16'(hlda), 16'd1);
    chk("R7 release after completion", {13'd0, bus_oe, ad_oe, ale}, 16'd0);
    hold = 1'b0;
    @(negedge clk);
    chk("R7 back to idle", 16'(hlda), 16'd0);
    run_cycle(3'd2, 16'h0708, 8'hE1, 0, 8'h00, 1'b0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule